// File: doc/BRIEF.md
# SPI Daisy-Chain Host Sequencer

This block is a host-side SPI master for a chain of up to `MAX_DEV` identical slaves. All slaves share one serial clock and one active-low select. Each slave's data output feeds the next slave's data input, and the last slave's output returns to the host. Every slave takes a fixed 16-bit frame per select period: a command byte made of a 3-bit opcode and a 5-bit register address, then a data byte. The host presents an array holding one opcode, address and data value per device, together with a read/write flag and the chain length. The block turns this into the concatenated bit stream, clocks it out in SPI mode 0 at a programmable rate, and reports completion.

A write is a single select period. A read takes two select periods. The first carries the read frames. The second is filled with no-operation frames, and during it the slaves shift back their answers. The block splits the returned stream into per-device frames, checks each frame's echo header, and stores the data bytes that are valid. Between two select periods the select line stays high for a guaranteed deselect time.

Top module: `spi_chain_host`

## Requirements
- R1: After reset, cs_no=1, sck_o=0, mosi_o=0, busy_o=0, done_o=0, and rd_data_o and rd_err_o are all zero.
- R2: A write command produces exactly one cs_no-low period with 16*n rising SCK edges. The first frame sent belongs to device n-1 and the last to device 0. Each frame is {op[2:0], addr[4:0], data[7:0]}, sent MSB first.
- R3: SCK is low whenever cs_no is high. MOSI changes only while SCK is low, either at a falling SCK edge or when select is asserted, so it is stable at every rising edge, where MISO is sampled.
- R4: Each SCK half period lasts cmd_div_i+1 clock cycles. The divisor is latched when the command is accepted, and the first rising edge comes one half period after cs_no falls.
- R5: Between two select periods, cs_no stays high for at least DESEL_CYC = SYS_CLK_MHZ*DESEL_NS/1000 clock cycles. With the defaults this is 400 cycles, or 2 us at 200 MHz.
- R6: A read command makes two select periods. The first sends the read frames in the R2 order, with the data byte replaced by 00h. The second sends 16*n zero bits, which are no-operation frames with opcode 000.
- R7: In the second read period, the k-th received 16-bit frame (k=0 first) belongs to device n-1-k. If it is accepted, its low byte goes to rd_data_o[8*dev +: 8].
- R8: A received frame is accepted only if bits [15:13] are 111b and bits [12:8] equal the address requested for that device. Otherwise rd_err_o[dev] is set and that device's rd_data_o byte keeps its value. Both outputs are cleared when a read command is accepted.
- R9: busy_o is high from the cycle after acceptance until the deselect time after the last select period has ended. done_o pulses for one cycle as busy_o falls. cmd_valid_i is ignored while busy_o is high.
- R10: A command with cmd_ndev_i equal to 0 or greater than MAX_DEV is ignored: no select period starts and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| cmd_ndev_i | input | 4 | Chain length, 1 to MAX_DEV |
| cmd_div_i | input | 8 | SCK half period minus one, in clock cycles |
| cmd_op_i | input | 24 | Opcode for each device, 3 bits per device |
| cmd_addr_i | input | 40 | Register address for each device, 5 bits per device |
| cmd_data_i | input | 64 | Write data for each device, 8 bits per device |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 64 | Read data for each device |
| rd_err_o | output | 8 | Echo-check failure for each device |
| cs_no | output | 1 | Chain select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to device 0 |
| miso_i | input | 1 | Serial data from device n-1 |

## Verification
The deselect and mode-0 properties assume that the command fields stay fixed from acceptance to completion. The block latches them, so this holds regardless of what the inputs do. The properties also assume that MISO from the chain model changes only on falling SCK edges. The chain model in the bench shifts its response only on those edges. Commands are driven on the falling system clock edge, and a second command is raised during a read on purpose, so the property that idle means a high select sees both the accepted request and the ignored one.

// File: rtl/spi_chain_host_pkg.sv
package spi_chain_host_pkg;
  localparam int OP_W    = 3;
  localparam int AD_W    = 5;
  localparam int DT_W    = 8;
  localparam int FRAME_W = OP_W + AD_W + DT_W;
  localparam logic [OP_W-1:0] ECHO_MARK = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/spi_chain_timer.sv
module spi_chain_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/spi_chain_tx_sel.sv
module spi_chain_tx_sel
  import spi_chain_host_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int DEVW    = 3,
  parameter int BITW    = 7
) (
  input  logic [MAX_DEV*OP_W-1:0] op_i,
  input  logic [MAX_DEV*AD_W-1:0] addr_i,
  input  logic [MAX_DEV*DT_W-1:0] data_i,
  input  logic [DEVW:0]           n_i,
  input  logic [BITW-1:0]         bit_i,
  input  logic                    nop_i,
  input  logic                    dummy_i,
  output logic                    bit_o
);
  logic [DEVW:0]        dev_full;
  logic [DEVW-1:0]      dev;
  logic [FRAME_W-1:0]   word;

  always_comb begin
    // frame f on the wire belongs to device n-1-f
    dev_full = n_i - {1'b0, bit_i[BITW-1:4]} - (DEVW+1)'(1);
    dev      = dev_full[DEVW-1:0];
    word     = {op_i[dev*OP_W +: OP_W], addr_i[dev*AD_W +: AD_W],
                dummy_i ? 8'h00 : data_i[dev*DT_W +: DT_W]};
    bit_o    = nop_i ? 1'b0 : word[4'd15 - bit_i[3:0]];
  end
endmodule

// File: rtl/spi_chain_rx_cap.sv
module spi_chain_rx_cap
  import spi_chain_host_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int DEVW    = 3,
  parameter int BITW    = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    smp_i,
  input  logic                    miso_i,
  input  logic [DEVW:0]           n_i,
  input  logic [BITW-1:0]         bit_i,
  input  logic [MAX_DEV*AD_W-1:0] addr_i,
  output logic [MAX_DEV*DT_W-1:0] rd_data_o,
  output logic [MAX_DEV-1:0]      rd_err_o
);
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [DEVW:0]      dev_full;
  logic [DEVW-1:0]    dev;
  logic               good;

  always_comb begin
    frame    = {sh_q, miso_i};
    dev_full = n_i - {1'b0, bit_i[BITW-1:4]} - (DEVW+1)'(1);
    dev      = dev_full[DEVW-1:0];
    good     = (frame[15:13] == ECHO_MARK) && (frame[12:8] == addr_i[dev*AD_W +: AD_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      rd_data_o <= '0;
      rd_err_o  <= '0;
    end else if (clear_i) begin
      sh_q      <= '0;
      rd_data_o <= '0;
      rd_err_o  <= '0;
    end else if (smp_i) begin
      sh_q <= frame[FRAME_W-2:0];
      if (bit_i[3:0] == 4'd15) begin
        if (good) rd_data_o[dev*DT_W +: DT_W] <= frame[7:0];
        else      rd_err_o[dev]               <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_chain_host.sv
module spi_chain_host
  import spi_chain_host_pkg::*;
#(
  parameter int MAX_DEV     = 8,
  parameter int DIV_W       = 8,
  parameter int SYS_CLK_MHZ = 200,
  parameter int DESEL_NS    = 2000,
  localparam int DEVW       = $clog2(MAX_DEV),
  localparam int BITW       = DEVW + 4,
  localparam int DESEL_CYC  = SYS_CLK_MHZ * DESEL_NS / 1000,
  localparam int GAP_W      = $clog2(DESEL_CYC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic                    cmd_read_i,
  input  logic [DEVW:0]           cmd_ndev_i,
  input  logic [DIV_W-1:0]        cmd_div_i,
  input  logic [MAX_DEV*OP_W-1:0] cmd_op_i,
  input  logic [MAX_DEV*AD_W-1:0] cmd_addr_i,
  input  logic [MAX_DEV*DT_W-1:0] cmd_data_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [MAX_DEV*DT_W-1:0] rd_data_o,
  output logic [MAX_DEV-1:0]      rd_err_o,
  output logic                    cs_no,
  output logic                    sck_o,
  output logic                    mosi_o,
  input  logic                    miso_i
);
  seq_st_e                 st_q;
  logic                    rd_q, nop_q, sck_q, done_q;
  logic [DEVW:0]           n_q;
  logic [DIV_W-1:0]        div_q;
  logic [MAX_DEV*OP_W-1:0] op_q;
  logic [MAX_DEV*AD_W-1:0] addr_q;
  logic [MAX_DEV*DT_W-1:0] data_q;
  logic [BITW-1:0]         bit_q;
  logic [BITW:0]           last_idx;
  logic                    accept, sck_tick, gap_tick, tx_bit, is_last, smp;

  assign accept   = (st_q == ST_IDLE) && cmd_valid_i && (cmd_ndev_i != '0) &&
                    (cmd_ndev_i <= (DEVW+1)'(MAX_DEV));
  assign last_idx = {n_q, 4'b0000} - (BITW+1)'(1);
  assign is_last  = ({1'b0, bit_q} == last_idx);
  assign smp      = (st_q == ST_ACT) && sck_tick && !sck_q && nop_q;

  spi_chain_timer #(.CW(DIV_W)) u_sck_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (st_q == ST_ACT),
    .lim_i (div_q), .tick_o (sck_tick)
  );

  spi_chain_timer #(.CW(GAP_W)) u_gap_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (st_q == ST_GAP),
    .lim_i (GAP_W'(DESEL_CYC - 1)), .tick_o (gap_tick)
  );

  spi_chain_tx_sel #(.MAX_DEV(MAX_DEV), .DEVW(DEVW), .BITW(BITW)) u_tx (
    .op_i (op_q), .addr_i (addr_q), .data_i (data_q), .n_i (n_q),
    .bit_i (bit_q), .nop_i (nop_q), .dummy_i (rd_q), .bit_o (tx_bit)
  );

  spi_chain_rx_cap #(.MAX_DEV(MAX_DEV), .DEVW(DEVW), .BITW(BITW)) u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (accept && cmd_read_i),
    .smp_i (smp), .miso_i (miso_i), .n_i (n_q), .bit_i (bit_q),
    .addr_i (addr_q), .rd_data_o (rd_data_o), .rd_err_o (rd_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      nop_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      n_q    <= '0;
      div_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          rd_q   <= cmd_read_i;
          nop_q  <= 1'b0;
          n_q    <= cmd_ndev_i;
          div_q  <= cmd_div_i;
          op_q   <= cmd_op_i;
          addr_q <= cmd_addr_i;
          data_q <= cmd_data_i;
          bit_q  <= '0;
          sck_q  <= 1'b0;
          st_q   <= ST_ACT;
        end
        ST_ACT: if (sck_tick) begin
          if (!sck_q) sck_q <= 1'b1;
          else begin
            sck_q <= 1'b0;
            if (is_last) st_q  <= ST_GAP;
            else         bit_q <= bit_q + BITW'(1);
          end
        end
        ST_GAP: if (gap_tick) begin
          if (rd_q && !nop_q) begin
            nop_q <= 1'b1;
            bit_q <= '0;
            st_q  <= ST_ACT;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = (st_q != ST_ACT);
  assign sck_o  = sck_q;
  assign mosi_o = (st_q == ST_ACT) ? tx_bit : 1'b0;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/spi_chain_host_chk.sv
module spi_chain_host_chk #(
  parameter int DESEL_CYC = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sck_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_cnt <= DESEL_CYC;
    else if (!cs_no)              hi_cnt <= 0;
    else if (hi_cnt < DESEL_CYC)  hi_cnt <= hi_cnt + 1;
  end

  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  p_mosi_at_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));
  p_desel_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= DESEL_CYC));
  p_idle_cs_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind spi_chain_host spi_chain_host_chk #(.DESEL_CYC(DESEL_CYC)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .cs_no (cs_no), .sck_o (sck_o),
  .mosi_o (mosi_o), .busy_o (busy_o), .done_o (done_o)
);

// File: tb/tb_spi_chain_host.sv
`timescale 1ns/1ps
module tb_spi_chain_host;
  localparam int MAXD = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [3:0] cmd_ndev = '0;
  logic [7:0] cmd_div = '0;
  logic [MAXD*3-1:0] cmd_op = '0;
  logic [MAXD*5-1:0] cmd_addr = '0;
  logic [MAXD*8-1:0] cmd_data = '0;
  logic busy, done, cs_n, sck, mosi;
  logic miso = 1'b0;
  logic [MAXD*8-1:0] rd_data;
  logic [MAXD-1:0] rd_err;

  always #2.5 clk = ~clk;

  spi_chain_host dut (
    .clk_i (clk), .rst_ni (rst_ni), .cmd_valid_i (cmd_valid), .cmd_read_i (cmd_read),
    .cmd_ndev_i (cmd_ndev), .cmd_div_i (cmd_div), .cmd_op_i (cmd_op),
    .cmd_addr_i (cmd_addr), .cmd_data_i (cmd_data), .busy_o (busy), .done_o (done),
    .rd_data_o (rd_data), .rd_err_o (rd_err), .cs_no (cs_n), .sck_o (sck),
    .mosi_o (mosi), .miso_i (miso)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [2:0] op_a [MAXD];
  logic [4:0] ad_a [MAXD];
  logic [7:0] dt_a [MAXD];
  logic [7:0] rsp_dt [MAXD];

  int sess = 0, rise0 = 0, rise1 = 0;
  logic [0:127] cap0, cap1, resp_q, resp_img;
  bit resp_en = 0;
  time t_r0, t_r1, t_up1, t_dn2;

  always @(negedge cs_n) begin
    sess = sess + 1;
    if (sess == 2) t_dn2 = $time;
    resp_q = (sess == 2 && resp_en) ? resp_img : '0;
    miso = resp_q[0];
  end
  always @(posedge cs_n) if (sess == 1) t_up1 = $time;
  always @(negedge sck) if (!cs_n) begin
    resp_q = resp_q << 1;
    miso = resp_q[0];
  end
  always @(posedge sck) begin
    if (sess == 1 && rise0 < 128) begin
      if (rise0 == 0) t_r0 = $time;
      if (rise0 == 1) t_r1 = $time;
      cap0[rise0] = mosi;
      rise0++;
    end else if (sess == 2 && rise1 < 128) begin
      cap1[rise1] = mosi;
      rise1++;
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pack();
    for (int d = 0; d < MAXD; d++) begin
      cmd_op[d*3 +: 3]   = op_a[d];
      cmd_addr[d*5 +: 5] = ad_a[d];
      cmd_data[d*8 +: 8] = dt_a[d];
    end
  endtask

  function automatic logic [0:127] exp_stream(int n, bit rd);
    logic [0:127] s = '0;
    for (int k = 0; k < 16*n; k++) begin
      int d = n - 1 - k/16;
      logic [15:0] w = {op_a[d], ad_a[d], rd ? 8'h00 : dt_a[d]};
      s[k] = w[15 - k%16];
    end
    return s;
  endfunction

  task automatic start(bit rd, int n, int dv);
    sess = 0; rise0 = 0; rise1 = 0; cap0 = '0; cap1 = '0;
    @(negedge clk);
    cmd_read = rd; cmd_ndev = 4'(n); cmd_div = 8'(dv); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(string req);
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen && !busy, req, {126'd0, seen, busy}, 128'd2);
    @(negedge clk);
    chk(!done, req, 128'(done), 128'd0);
  endtask

  task automatic t_reset();
    chk(cs_n && !sck && !mosi && !busy && !done, "R1", {cs_n, sck, mosi, busy, done}, 128'h10);
    chk(rd_data == '0 && rd_err == '0, "R1", {rd_data, rd_err}, 128'd0);
  endtask

  task automatic t_write(int n, int dv);
    for (int d = 0; d < MAXD; d++) begin
      op_a[d] = 3'b110; ad_a[d] = 5'(d + 3*n); dt_a[d] = 8'(8'hA5 ^ (d*37 + n));
    end
    pack();
    start(0, n, dv);
    chk(busy, "R9", 128'(busy), 128'd1);
    wait_done("R9");
    chk(sess == 1, "R2", 128'(sess), 128'd1);
    chk(rise0 == 16*n, "R2", 128'(rise0), 128'(16*n));
    chk(cap0 == exp_stream(n, 0), "R2", cap0, exp_stream(n, 0));
    chk((t_r1 - t_r0) == 10*(dv+1), "R4", 128'(t_r1 - t_r0), 128'(10*(dv+1)));
  endtask

  task automatic t_read(int n, int dv, logic [7:0] bad_mark, logic [7:0] bad_addr, bit poke);
    logic [63:0] prev = rd_data;
    logic [0:127] img = '0;
    for (int d = 0; d < MAXD; d++) begin
      op_a[d] = 3'b100; ad_a[d] = 5'(7*d + n); dt_a[d] = 8'hFF; rsp_dt[d] = 8'(8'h3C + 17*d + n);
    end
    pack();
    for (int d = 0; d < n; d++) begin
      logic [15:0] w = {bad_mark[d] ? 3'b101 : 3'b111, bad_addr[d] ? ad_a[d] ^ 5'h1 : ad_a[d], rsp_dt[d]};
      int f = n - 1 - d;
      for (int j = 0; j < 16; j++) img[16*f + j] = w[15 - j];
    end
    resp_img = img; resp_en = 1;
    start(1, n, dv);
    if (poke) begin
      repeat (50) @(negedge clk);
      cmd_read = 0; cmd_ndev = 4'd2; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_done("R9");
    repeat (20) @(negedge clk);
    chk(sess == 2 && !busy, "R6", 128'(sess), 128'd2);
    chk(rise0 == 16*n && rise1 == 16*n, "R6", 128'(rise1), 128'(16*n));
    chk(cap0 == exp_stream(n, 1), "R6", cap0, exp_stream(n, 1));
    chk(cap1 == '0, "R6", cap1, 128'd0);
    chk((t_dn2 - t_up1) >= 2000, "R5", 128'(t_dn2 - t_up1), 128'd2000);
    for (int d = 0; d < MAXD; d++) begin
      bit bad = (d < n) && (bad_mark[d] || bad_addr[d]);
      logic [7:0] ed = (d < n && !bad) ? rsp_dt[d] : 8'h00;
      chk(rd_err[d] == bad, "R8", 128'(rd_err[d]), 128'(bad));
      chk(rd_data[d*8 +: 8] == ed, bad ? "R8" : "R7", 128'(rd_data[d*8 +: 8]), 128'(ed));
    end
    resp_en = 0;
    if (prev == 64'd1) $display("note");
  endtask

  task automatic t_bad_n(int n);
    start(0, n, 0);
    repeat (40) @(negedge clk);
    chk(!busy && sess == 0 && cs_n, "R10", {busy, 4'(sess)}, 128'd0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write(3, 1);
    t_write(1, 3);
    t_write(MAXD, 0);
    t_read(3, 0, 8'h00, 8'h00, 0);
    t_read(4, 1, 8'h02, 8'h04, 0);
    t_read(MAXD, 0, 8'h80, 8'h01, 1);
    t_bad_n(0);
    t_bad_n(MAXD + 1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule